// File: doc/BRIEF.md
# DRAM Power-Down and Clock-Change Sequencer

This controller-side state machine puts a DDR SDRAM into a power-down state by pulling CKE low and later brings it back out. A plain power-down request gives active power-down if any bank is still open, or precharge power-down if all banks are closed. The sequencer reports which of the two it entered. It never drops CKE while a burst is running.

A clock-change request uses precharge power-down as a safe window for changing the input clock frequency. Once CKE has been low for the minimum number of clocks, the sequencer raises a flag that lets the clock generator retune. It keeps CKE low until the request is withdrawn and the clock reports stable. On exit it asks the command arbiter for a NOP, then an extended mode-register write that resets the DLL, and then, if enabled, a mode-register write. It then waits out the DLL relock time before it reports ready. A clock-change request made while a bank is open is refused with an error pulse.

Top module: `dram_pd_seq`

## Requirements
- R1: CKE goes low on the clock after a power-down request is seen in the ready state with no burst in progress. While the burst flag is high, CKE stays high and the request waits.
- R2: pd_kind_o is latched at power-down entry: 1 for precharge power-down (all banks idle), 0 for active power-down.
- R3: When the power-down request drops, CKE is high on the next clock. A NOP (cmd_o = 2'd0) is requested until granted, and ready_o returns on the clock after the grant.
- R4: A clock-change request in the ready state with no burst and all banks idle takes CKE low. clk_chg_ok_o rises only after CKE has been low for CKE_LOW_MIN clocks (default 2).
- R5: A clock-change request with any bank open is refused. CKE stays high, and chg_err_o is high on the next clock, once for each refused cycle.
- R6: During a clock change, CKE stays low while the change request is held or clk_stable_i is low.
- R7: After a clock change, the exit requests a NOP (2'd0), then an extended mode-register write (2'd1), then, if USE_MRS is set, a mode-register write (2'd2). Each command is held with a stable code until granted.
- R8: After the last grant of a clock-change exit, ready_o stays low for exactly RELOCK_CYC clocks (default 200).
- R9: After reset, CKE is high, ready_o is high, and no command, permission flag or error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Level request for power-down |
| clk_chg_req_i | input | 1 | Level request for a clock frequency change |
| burst_busy_i | input | 1 | A read or write burst is in progress |
| banks_idle_i | input | 1 | All banks are precharged |
| clk_stable_i | input | 1 | Input clock is stable |
| cmd_gnt_i | input | 1 | Arbiter accepted the requested command |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cmd_req_o | output | 1 | Command request to the arbiter |
| cmd_o | output | 2 | Command code: 0 NOP, 1 extended mode write, 2 mode write |
| pd_kind_o | output | 1 | 1 precharge power-down, 0 active power-down |
| clk_chg_ok_o | output | 1 | Clock frequency may be changed now |
| chg_err_o | output | 1 | Clock-change request refused |
| ready_o | output | 1 | Normal operation allowed |

## Verification
The bench holds a power-down request during a burst. A design that ignored the burst flag would drop CKE mid-burst. It counts the clocks between CKE falling and the permission flag rising, which catches a window that is off by one. It withdraws the change request while the clock is still unstable, where a careless exit would raise CKE on a changing clock. It withholds grants to show each exit command is held rather than skipped, and it counts the relock wait exactly. It also sends a change request with a bank open, which a faulty design would accept into active power-down.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_PD, ST_CHG_WAIT, ST_CHG_OK, ST_EXIT_NOP, ST_DLL_RST, ST_MRS, ST_RELOCK
  } pd_state_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_EMRS = 2'd1,
    CMD_MRS  = 2'd2
  } pd_cmd_e;
endpackage

// File: rtl/dram_pd_gate.sv
module dram_pd_gate (
  input  logic pd_req_i,
  input  logic clk_chg_req_i,
  input  logic burst_busy_i,
  input  logic banks_idle_i,
  output logic go_pd_o,
  output logic go_chg_o,
  output logic refuse_o
);
  logic quiet;
  assign quiet    = !burst_busy_i;
  assign go_chg_o = quiet && clk_chg_req_i && banks_idle_i;
  assign refuse_o = quiet && clk_chg_req_i && !banks_idle_i;
  assign go_pd_o  = quiet && pd_req_i && !clk_chg_req_i;
endmodule

// File: rtl/dram_pd_timer.sv
module dram_pd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (cnt_o != {CNT_W{1'b1}}) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_pd_cmd.sv
module dram_pd_cmd
  import dram_pd_pkg::*;
(
  input  pd_state_e state_i,
  output logic      cke_o,
  output logic      cmd_req_o,
  output pd_cmd_e   cmd_o,
  output logic      clk_chg_ok_o,
  output logic      ready_o
);
  always_comb begin
    cke_o        = 1'b1;
    cmd_req_o    = 1'b0;
    cmd_o        = CMD_NOP;
    clk_chg_ok_o = 1'b0;
    ready_o      = 1'b0;
    unique case (state_i)
      ST_RUN:      ready_o = 1'b1;
      ST_PD,
      ST_CHG_WAIT: cke_o = 1'b0;
      ST_CHG_OK: begin
        cke_o        = 1'b0;
        clk_chg_ok_o = 1'b1;
      end
      ST_EXIT_NOP: cmd_req_o = 1'b1;
      ST_DLL_RST: begin
        cmd_req_o = 1'b1;
        cmd_o     = CMD_EMRS;
      end
      ST_MRS: begin
        cmd_req_o = 1'b1;
        cmd_o     = CMD_MRS;
      end
      ST_RELOCK:   ;
      default:     ;
    endcase
  end
endmodule

// File: rtl/dram_pd_seq.sv
module dram_pd_seq
  import dram_pd_pkg::*;
#(
  parameter int CKE_LOW_MIN = 2,
  parameter int RELOCK_CYC  = 200,
  parameter bit USE_MRS     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       clk_chg_req_i,
  input  logic       burst_busy_i,
  input  logic       banks_idle_i,
  input  logic       clk_stable_i,
  input  logic       cmd_gnt_i,
  output logic       cke_o,
  output logic       cmd_req_o,
  output logic [1:0] cmd_o,
  output logic       pd_kind_o,
  output logic       clk_chg_ok_o,
  output logic       chg_err_o,
  output logic       ready_o
);
  localparam int MAX_CNT = (RELOCK_CYC > CKE_LOW_MIN) ? RELOCK_CYC : CKE_LOW_MIN;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(CKE_LOW_MIN - 1);
  localparam logic [CNT_W-1:0] RELOCK_LAST = CNT_W'(RELOCK_CYC - 1);

  pd_state_e        state_q, state_d;
  logic             chg_q;
  logic             go_pd, go_chg, refuse;
  logic [CNT_W-1:0] cnt;
  pd_cmd_e          cmd_e;

  dram_pd_gate u_gate (
    .pd_req_i      (pd_req_i),
    .clk_chg_req_i (clk_chg_req_i),
    .burst_busy_i  (burst_busy_i),
    .banks_idle_i  (banks_idle_i),
    .go_pd_o       (go_pd),
    .go_chg_o      (go_chg),
    .refuse_o      (refuse)
  );

  // restart the count on every state change
  dram_pd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (go_chg) state_d = ST_CHG_WAIT;
                   else if (go_pd) state_d = ST_PD;
      ST_PD:       if (!pd_req_i) state_d = ST_EXIT_NOP;
      ST_CHG_WAIT: if (cnt == LOW_LAST) state_d = ST_CHG_OK;
      ST_CHG_OK:   if (!clk_chg_req_i && clk_stable_i) state_d = ST_EXIT_NOP;
      ST_EXIT_NOP: if (cmd_gnt_i) state_d = chg_q ? ST_DLL_RST : ST_RUN;
      ST_DLL_RST:  if (cmd_gnt_i) state_d = USE_MRS ? ST_MRS : ST_RELOCK;
      ST_MRS:      if (cmd_gnt_i) state_d = ST_RELOCK;
      ST_RELOCK:   if (cnt == RELOCK_LAST) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      chg_q     <= 1'b0;
      pd_kind_o <= 1'b0;
      chg_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      chg_err_o <= (state_q == ST_RUN) && refuse;
      if (state_q == ST_RUN && go_chg) begin
        chg_q     <= 1'b1;
        pd_kind_o <= 1'b1;
      end else if (state_q == ST_RUN && go_pd) begin
        chg_q     <= 1'b0;
        pd_kind_o <= banks_idle_i;
      end else if (state_d == ST_RUN) begin
        chg_q <= 1'b0;
      end
    end
  end

  dram_pd_cmd u_cmd (
    .state_i      (state_q),
    .cke_o        (cke_o),
    .cmd_req_o    (cmd_req_o),
    .cmd_o        (cmd_e),
    .clk_chg_ok_o (clk_chg_ok_o),
    .ready_o      (ready_o)
  );
  assign cmd_o = cmd_e;
endmodule

// File: rtl/dram_pd_seq_chk.sv
module dram_pd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pd_req_i,
  input logic       clk_chg_req_i,
  input logic       burst_busy_i,
  input logic       banks_idle_i,
  input logic       clk_stable_i,
  input logic       cmd_gnt_i,
  input logic       cke_o,
  input logic       cmd_req_o,
  input logic [1:0] cmd_o,
  input logic       pd_kind_o,
  input logic       clk_chg_ok_o,
  input logic       chg_err_o,
  input logic       ready_o
);
  AST_BURST_KEEPS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && burst_busy_i |=> cke_o); // R1
  AST_OK_ONLY_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_chg_ok_o |-> !cke_o); // R4
  AST_OK_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_chg_ok_o) |-> !$past(cke_o) && !$past(cke_o, 2)); // R4
  AST_ERR_NO_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_err_o |-> cke_o); // R5
  AST_HOLD_UNSTABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_chg_ok_o && !clk_stable_i |=> !cke_o); // R6
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && !cmd_gnt_i |=> cmd_req_o && $stable(cmd_o)); // R7
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cke_o && !cmd_req_o && !clk_chg_ok_o); // R9
endmodule

bind dram_pd_seq dram_pd_seq_chk u_chk (.*);

// File: tb/dram_pd_seq_test.sv
module dram_pd_seq_test;
  localparam int CLK_P  = 10;
  localparam int RELOCK = 200;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pd_req = 0, chg_req = 0, burst = 0, idle = 0, stable = 1, gnt = 0;
  logic       cke, cmd_req, kind, ok, err, ready;
  logic [1:0] cmd;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_pd_seq #(.RELOCK_CYC(RELOCK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .clk_chg_req_i(chg_req),
    .burst_busy_i(burst), .banks_idle_i(idle), .clk_stable_i(stable),
    .cmd_gnt_i(gnt), .cke_o(cke), .cmd_req_o(cmd_req), .cmd_o(cmd),
    .pd_kind_o(kind), .clk_chg_ok_o(ok), .chg_err_o(err), .ready_o(ready)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R9 cke", cke, 1); chk("R9 ready", ready, 1);
    chk("R9 cmd_req", cmd_req, 0); chk("R9 ok", ok, 0); chk("R9 err", err, 0);
  endtask

  task automatic t_active_pd();
    idle = 0; pd_req = 1; tick();
    chk("R1 cke low", cke, 0); chk("R2 active kind", kind, 0); chk("R1 ready low", ready, 0);
    pd_req = 0; tick();
    chk("R3 cke high", cke, 1); chk("R3 nop req", cmd_req, 1); chk("R3 nop code", cmd, 0);
    gnt = 1; tick(); gnt = 0;
    chk("R3 ready", ready, 1); chk("R3 req off", cmd_req, 0);
  endtask

  task automatic t_burst_block();
    burst = 1; idle = 1; pd_req = 1;
    for (int i = 0; i < 3; i++) begin tick(); chk("R1 burst holds cke", cke, 1); end
    burst = 0; tick();
    chk("R1 entry after burst", cke, 0); chk("R2 precharge kind", kind, 1);
    pd_req = 0; tick(); gnt = 1; tick(); gnt = 0;
    chk("R3 back ready", ready, 1);
  endtask

  task automatic t_refuse();
    idle = 0; chg_req = 1; tick();
    chk("R5 err pulse", err, 1); chk("R5 cke high", cke, 1); chk("R5 no ok", ok, 0);
    chg_req = 0; tick();
    chk("R5 err clears", err, 0); chk("R5 still ready", ready, 1);
  endtask

  task automatic t_clk_change();
    int n;
    idle = 1; chg_req = 1; tick();
    chk("R4 cke low", cke, 0); chk("R4 ok early 0", ok, 0);
    tick(); chk("R4 ok early 1", ok, 0);
    tick(); chk("R4 ok after 2", ok, 1);
    stable = 0; tick(); chk("R6 held by req", cke, 0);
    chg_req = 0; tick(); chk("R6 held unstable", cke, 0); chk("R6 ok kept", ok, 1);
    stable = 1; tick();
    chk("R7 cke high", cke, 1); chk("R7 nop", cmd, 0); chk("R7 nop req", cmd_req, 1);
    tick(); chk("R7 nop held", cmd, 0); chk("R7 nop held req", cmd_req, 1);
    gnt = 1; tick();
    chk("R7 emrs", cmd, 1); chk("R7 emrs req", cmd_req, 1);
    tick(); chk("R7 mrs", cmd, 2); chk("R7 mrs req", cmd_req, 1);
    tick(); gnt = 0;
    chk("R8 relock no req", cmd_req, 0); chk("R8 not ready", ready, 0);
    n = 0;
    while (!ready && n < 1000) begin tick(); n++; end
    chk("R8 relock length", n, RELOCK);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4) rst_n = 1;
    tick();
    t_reset();
    t_active_pd();
    t_burst_block();
    t_refuse();
    t_clk_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule